// File: doc/BRIEF.md
# Configurable Parallel I/O Port

This block is a memory-mapped parallel port with a data register and a direction register. A processor reaches both over a small register bus that has an address, a write strobe, a read strobe and write and read data. Each pin is modelled as three separate signals: an input value, an output value and an output enable.

A static mode input selects how direction is set. In per-bit mode, every direction bit controls the pin of the same index. In whole-port mode, direction bit 0 alone sets every pin to input or every pin to output, and the other stored direction bits have no effect on the pins.

A read of the data register returns a mix of values. For pins driven as inputs it returns the live pin value, and for pins driven as outputs it returns the latched output value. Read data is registered and appears one cycle after the read strobe.

Top module: `pio_port`

## Requirements
- R1: While reset is asserted, `pin_oe_o`, `pin_o` and `rdata_o` are all zero, so every pin is an input.
- R2: A write to address 0 (data register) drives `pin_o` to the written value from the next cycle on, whatever the direction setting.
- R3: In per-bit mode (`mode_whole_i`=0), a write to address 1 (direction register) makes `pin_oe_o` equal the written value from the next cycle on, with 1 meaning output. For example, 0x34 makes bits 2, 4 and 5 outputs.
- R4: In whole-port mode (`mode_whole_i`=1), `pin_oe_o` is all ones when direction bit 0 is 1 and all zeros when it is 0. The other direction bits are ignored.
- R5: A read of address 0 returns `pin_i` for bits whose effective enable is 0 and the data register for bits whose enable is 1.
- R6: A read of address 1 returns the full stored direction value in both modes.
- R7: Addresses 2 and 3 are unmapped. Reads of them return zero, and writes to them change neither `pin_o` nor `pin_oe_o`.
- R8: `rdata_o` is loaded on the clock edge that follows a cycle with `rd_en_i` high, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_whole_i | input | 1 | 0 = per-bit direction, 1 = whole-port direction from bit 0 |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Registered read data |
| pin_i | input | WIDTH | Pin input values |
| pin_o | output | WIDTH | Pin output values |
| pin_oe_o | output | WIDTH | Pin output enables, 1 = drive |

## Verification
The bench sweeps all 256 direction values in both modes, so it catches a design that lets a high direction bit leak into whole-port mode or that inverts the enable polarity. It also sweeps all 256 data values, which catches a dropped or swapped bit in the data path. The read mix is tested with several direction patterns against varied pin values, and a design that returns the latch for input bits, or the pin for output bits, fails this test. Unmapped writes and reads, and the holding of `rdata_o` while pins change with no read strobe, catch faulty address decode and an ungated read register.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 1;

  typedef struct packed {
    logic hit_data;
    logic hit_dir;
  } reg_sel_t;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_t          sel_o,
  output logic              we_data_o,
  output logic              we_dir_o
);
  always_comb begin
    sel_o.hit_data = (addr_i == ADDR_W'(OFS_DATA));
    sel_o.hit_dir  = (addr_i == ADDR_W'(OFS_DIR));
    we_data_o      = we_i & sel_o.hit_data;
    we_dir_o       = we_i & sel_o.hit_dir;
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_data_i,
  input  logic             we_dir_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
    end else begin
      if (we_data_i) data_q_o <= wdata_i;
      if (we_dir_i)  dir_q_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/pio_dir_map.sv
module pio_dir_map #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             mode_whole_i,
  input  logic [WIDTH-1:0] dir_q_i,
  output logic [WIDTH-1:0] oe_o
);
  // whole-port mode: bit 0 governs every pin
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign oe_o[i] = mode_whole_i ? dir_q_i[0] : dir_q_i[i];
  end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  reg_sel_t         sel_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] data_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] oe_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (sel_i.hit_data)     rd_d = (pin_i & ~oe_i) | (data_q_i & oe_i);
    else if (sel_i.hit_dir) rd_d = dir_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_whole_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_en_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  reg_sel_t         sel;
  logic             we_data, we_dir;
  logic [WIDTH-1:0] data_q, dir_q, oe;

  pio_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .sel_o     (sel),
    .we_data_o (we_data),
    .we_dir_o  (we_dir)
  );

  pio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_data_i (we_data),
    .we_dir_i  (we_dir),
    .wdata_i   (wdata_i),
    .data_q_o  (data_q),
    .dir_q_o   (dir_q)
  );

  pio_dir_map #(.WIDTH(WIDTH)) u_dir_map (
    .mode_whole_i (mode_whole_i),
    .dir_q_i      (dir_q),
    .oe_o         (oe)
  );

  pio_rd_mux #(.WIDTH(WIDTH)) u_rd_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .sel_i    (sel),
    .pin_i    (pin_i),
    .data_q_i (data_q),
    .dir_q_i  (dir_q),
    .oe_i     (oe),
    .rdata_o  (rdata_o)
  );

  assign pin_o    = data_q;
  assign pin_oe_o = oe;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_whole_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              rd_en_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pin_o,
  input logic [WIDTH-1:0]  pin_oe_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (pin_oe_o == '0 && pin_o == '0 && rdata_o == '0);
    end
  end

  a_r2_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=> pin_o == $past(wdata_i));

  a_r3_perbit_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1) && !mode_whole_i)
      |=> (mode_whole_i || pin_oe_o == $past(wdata_i)));

  a_r4_whole_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_whole_i |-> (pin_oe_o == '0 || pin_oe_o == '1));

  a_r7_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > ADDR_W'(1)) |=> rdata_o == '0);

  a_r7_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > ADDR_W'(1)) |=> ($stable(pin_o) && (mode_whole_i != $past(mode_whole_i) || $stable(pin_oe_o))));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_whole_i (mode_whole_i),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .rd_en_i      (rd_en_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o)
);

// File: tb/pio_port_tb.sv
module pio_port_tb_top;
  localparam int unsigned W  = 8;
  localparam int unsigned AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic          rd = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out;
  logic [W-1:0]  pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pio_port #(.WIDTH(W), .ADDR_W(AW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_whole_i (mode),
    .addr_i       (addr),
    .we_i         (we),
    .rd_en_i      (rd),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .pin_i        (pin_in),
    .pin_o        (pin_out),
    .pin_oe_o     (pin_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdreg(logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [W-1:0] exp_oe(logic m, logic [W-1:0] d);
    return m ? {W{d[0]}} : d;
  endfunction

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] dir_pat [4] = '{8'h34, 8'h00, 8'hFF, 8'hA5};
    @(negedge clk);
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    check("R1 rdata", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: per-bit direction sweep, R6 readback
    mode = 1'b0;
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, W'(i));
      check("R3 oe", pin_oe, W'(i));
      rdreg(2'd1, r);
      check("R6 dir readback", r, W'(i));
    end
    wr(2'd1, 8'h34);
    check("R3 0x34", pin_oe, 8'h34);

    // R4: whole-port sweep, R6 readback
    mode = 1'b1;
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, W'(i));
      check("R4 oe", pin_oe, exp_oe(1'b1, W'(i)));
      rdreg(2'd1, r);
      check("R6 dir whole", r, W'(i));
    end

    // R2: data sweep with all outputs, then with all inputs
    mode = 1'b0;
    wr(2'd1, 8'hFF);
    for (int i = 0; i < 256; i++) begin
      wr(2'd0, W'(i));
      check("R2 pin_o", pin_out, W'(i));
      rdreg(2'd0, r);
      check("R5 out readback", r, W'(i));
    end
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC3);
    check("R2 pin_o input dir", pin_out, 8'hC3);

    // R5: mixed read in both modes
    wr(2'd0, 8'h5A);
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int k = 0; k < 4; k++) begin
        wr(2'd1, dir_pat[k]);
        for (int p = 0; p < 16; p++) begin
          logic [W-1:0] e;
          pin_in = W'(p * 37 + 11);
          e = (pin_in & ~exp_oe(mode, dir_pat[k])) | (8'h5A & exp_oe(mode, dir_pat[k]));
          rdreg(2'd0, r);
          check("R5 mixed read", r, e);
        end
      end
    end

    // R7: unmapped addresses
    mode = 1'b0;
    wr(2'd1, 8'h34);
    wr(2'd0, 8'h81);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    check("R7 pin_o", pin_out, 8'h81);
    check("R7 oe", pin_oe, 8'h34);
    rdreg(2'd2, r);
    check("R7 read 2", r, 8'h00);
    rdreg(2'd3, r);
    check("R7 read 3", r, 8'h00);

    // R8: hold without read strobe
    wr(2'd1, 8'h00);
    pin_in = 8'h3C;
    rdreg(2'd0, r);
    check("R8 load", r, 8'h3C);
    pin_in = 8'hE1;
    addr = 2'd0;
    repeat (3) @(negedge clk);
    check("R8 hold", rdata, 8'h3C);
    rdreg(2'd0, r);
    check("R8 reload", r, 8'hE1);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset oe", pin_oe, '0);
    check("R1 re-reset out", pin_out, '0);
    check("R1 re-reset rdata", rdata, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule